// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Insertion

This block shifts characters out on an asynchronous serial line. Software writes a character into a one-entry holding register. When the shifter is free and the transmitter is enabled, that character moves into the shifter and goes out as a frame: a low start bit, 8 or 9 data bits with the least significant bit first, and a high stop bit. If parity is enabled, the parity bit takes the place of the top data bit. An empty flag shows software when it can write the next character.

The enable input also drives idle insertion. An idle character is a run of logic 1 that lasts as long as one full frame. Each 0-to-1 edge of the enable queues one idle character. After the enable comes up from a quiet line, that idle character acts as a synchronizing preamble. If the enable drops and comes back while a frame is still shifting, the idle character follows that frame. A queued idle character always goes out before pending data. If the enable is still low when the stop bit of a data frame starts, the pending character is thrown away.

A baud-tick input paces the bit timing. Each bit lasts a fixed number of ticks. The block does not generate the baud rate.

Top module: `serial_tx`

## Requirements
- R1: After reset, `txd` is 1 and `tdr_empty` is 1.
- R2: A data frame is one 0 start bit, then the data bits LSB first, then one 1 stop bit. Each bit lasts 16 `baud_tick` pulses. With `char9`=0 the frame carries `wr_data[7:0]` (10 bits in total). With `char9`=1 it carries `wr_data[8:0]` (11 bits in total), and bit 8 is the ninth data bit.
- R3: With `par_en`=1, the parity bit replaces data bit 7 when `char9`=0 and data bit 8 when `char9`=1. It is computed over the data bits below it. With `par_odd`=0 the total count of ones, parity bit included, is even. With `par_odd`=1 that count is odd. Length and parity settings are sampled when a character moves into the shifter.
- R4: `tdr_empty` is 0 in the cycle after a write. It returns to 1 in the cycle after the held character moves into the shifter, unless a new write happens in that same cycle.
- R5: Each 0-to-1 edge of `tx_en` queues one idle character. An idle character is all 1s and lasts 10 bit times (`char9`=0) or 11 bit times (`char9`=1). A character can start only when `tx_en` has been 1 for the current cycle and the previous one. So after enable, the idle preamble goes out before any data.
- R6: A queued idle character is sent before a pending data character. If `tx_en` falls and rises again during a frame, the idle character goes out right after that frame, and the pending data follows it.
- R7: If `tx_en` is 0 in the cycle the stop bit of a data frame begins, the held character is discarded. `tdr_empty` then reads 1 from the next cycle on, unless a write happens in that same cycle.
- R8: While `tx_en` is 0, no character starts. A character already in progress completes. `txd` stays at 1 whenever no character is in progress.
- R9: While a character is in progress, `txd` changes only on a clock where `baud_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| char9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Parity insertion enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to transmit |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| tdr_empty | output | 1 | Holding register empty flag |
| txd | output | 1 | Serial output line |

## Verification
The assertions check four things on every cycle:
- the empty flag clears after each write;
- every data frame begins with a low start bit;
- an idle character never drives the line low;
- no character starts while the enable is low, and the line moves only on baud ticks.

The scenarios cover behaviour that needs a history to see: the bit order and parity values, the preamble after enable, the idle character placed ahead of pending data after a mid-frame toggle, and the discard that happens when the enable is still low when the stop bit begins. The bench's reference model follows each of these cycle by cycle.

// File: rtl/tx_pkg.sv
package tx_pkg;

    localparam int DATA_W  = 9;
    localparam int FRAME_W = DATA_W + 2;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef enum logic {
        CH_DATA = 1'b0,
        CH_IDLE = 1'b1
    } char_kind_e;

    typedef struct packed {
        logic char9;
        logic par_en;
        logic par_odd;
    } tx_cfg_t;

    // Bit count of one character, frame or idle
    function automatic logic [LEN_W-1:0] char_len(input logic char9);
        return char9 ? LEN_W'(FRAME_W) : LEN_W'(FRAME_W - 1);
    endfunction

    // Builds the frame, LSB goes on the line first
    function automatic logic [FRAME_W-1:0] make_frame(
        input logic [DATA_W-1:0] d,
        input tx_cfg_t           c
    );
        logic [DATA_W-1:0] body;
        body = d;
        if (!c.char9) begin
            body[DATA_W-1] = 1'b1;          // becomes the stop bit
        end
        if (c.par_en) begin
            if (c.char9) begin
                body[DATA_W-1] = (^d[DATA_W-2:0]) ^ c.par_odd;
            end else begin
                body[DATA_W-2] = (^d[DATA_W-3:0]) ^ c.par_odd;
            end
        end
        return {1'b1, body, 1'b0};
    endfunction

endpackage

// File: rtl/tx_holding_reg.sv
module tx_holding_reg
    import tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic              drop,
    output logic              full,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            data_q <= '0;
        end else if (wr_en) begin
            full   <= 1'b1;
            data_q <= wr_data;
        end else if (take || drop) begin
            full   <= 1'b0;
        end
    end

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               baud_tick,
    input  logic               start,
    input  char_kind_e         start_kind,
    input  logic [FRAME_W-1:0] start_bits,
    input  logic [LEN_W-1:0]   start_len,
    output logic               busy,
    output char_kind_e         kind,
    output logic               txd,
    output logic               stop_entry
);

    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;
    logic [CNT_W-1:0]   tick_cnt;
    logic               bit_end;

    assign bit_end    = busy && baud_tick && (tick_cnt == CNT_W'(TICKS_PER_BIT - 1));
    assign stop_entry = bit_end && (left == LEN_W'(2)) && (kind == CH_DATA);
    assign txd        = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            kind     <= CH_IDLE;
            shreg    <= '1;
            left     <= '0;
            tick_cnt <= '0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                kind     <= start_kind;
                shreg    <= start_bits;
                left     <= start_len;
                tick_cnt <= '0;
            end
        end else if (baud_tick) begin
            if (bit_end) begin
                tick_cnt <= '0;
                shreg    <= {1'b1, shreg[FRAME_W-1:1]};
                left     <= left - LEN_W'(1);
                if (left == LEN_W'(1)) begin
                    busy <= 1'b0;
                end
            end else begin
                tick_cnt <= tick_cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tx_char_sched.sv
module tx_char_sched
    import tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       busy,
    input  logic       full,
    input  logic       stop_entry,
    output logic       launch,
    output char_kind_e launch_kind,
    output logic       take,
    output logic       drop
);

    logic en_q;
    logic idle_pend;
    logic ready;

    assign ready       = !busy && tx_en && en_q;
    assign launch      = ready && (idle_pend || full);
    assign launch_kind = idle_pend ? CH_IDLE : CH_DATA;
    assign take        = ready && !idle_pend && full;
    assign drop        = stop_entry && !tx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            idle_pend <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (tx_en && !en_q) begin
                idle_pend <= 1'b1;
            end else if (ready && idle_pend) begin
                idle_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              char9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              tdr_empty,
    output logic              txd
);

    logic               full_w;
    logic [DATA_W-1:0]  hold_data_w;
    logic               take_w;
    logic               drop_w;
    logic               launch_w;
    char_kind_e         launch_kind_w;
    logic               busy_w;
    char_kind_e         kind_w;
    logic               stop_entry_w;
    tx_cfg_t            cfg_w;
    logic [FRAME_W-1:0] bits_w;

    assign cfg_w     = '{char9: char9, par_en: par_en, par_odd: par_odd};
    assign bits_w    = (launch_kind_w == CH_IDLE) ? '1 : make_frame(hold_data_w, cfg_w);
    assign tdr_empty = !full_w;

    tx_holding_reg hold_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take_w),
        .drop    (drop_w),
        .full    (full_w),
        .data_q  (hold_data_w)
    );

    tx_char_sched sched_i (
        .clk         (clk),
        .rst         (rst),
        .tx_en       (tx_en),
        .busy        (busy_w),
        .full        (full_w),
        .stop_entry  (stop_entry_w),
        .launch      (launch_w),
        .launch_kind (launch_kind_w),
        .take        (take_w),
        .drop        (drop_w)
    );

    tx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) shift_i (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .start      (launch_w),
        .start_kind (launch_kind_w),
        .start_bits (bits_w),
        .start_len  (char_len(char9)),
        .busy       (busy_w),
        .kind       (kind_w),
        .txd        (txd),
        .stop_entry (stop_entry_w)
    );

endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker
    import tx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tx_en,
    input logic       wr_en,
    input logic       baud_tick,
    input logic       tdr_empty,
    input logic       txd,
    input logic       busy,
    input char_kind_e kind
);

    assert_empty_clear_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tdr_empty);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && kind == CH_DATA) |-> !txd);

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == CH_IDLE) |-> txd);

    assert_no_launch_R8: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !$rose(busy));

    assert_tick_paced_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick) |=> $stable(txd));

endmodule

bind serial_tx serial_tx_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .wr_en     (wr_en),
    .baud_tick (baud_tick),
    .tdr_empty (tdr_empty),
    .txd       (txd),
    .busy      (busy_w),
    .kind      (kind_w)
);

// File: tb/serial_tx_tb_top.sv
module serial_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       char9 = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       tdr_empty;
    logic       txd;

    int total = 0;
    int fails = 0;
    string phase = "R2";

    always #4 clk = ~clk;

    serial_tx dut_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .char9(char9), .par_en(par_en),
        .par_odd(par_odd), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .tdr_empty(tdr_empty), .txd(txd)
    );

    // ---------------- reference model ----------------
    bit m_q[$];
    bit m_full = 0;
    int m_data = 0;
    bit m_busy = 0;
    bit m_cur_idle = 0;
    bit m_idle_pend = 0;
    bit m_en_q = 0;
    int m_tick = 0;

    function automatic void push_frame(int d, bit m9, bit pe, bit po);
        int n;
        int ones;
        bit b[9];
        n = m9 ? 9 : 8;
        for (int i = 0; i < n; i++) b[i] = bit'((d >> i) & 1);
        if (pe) begin
            ones = 0;
            for (int i = 0; i < n - 1; i++) ones += int'(b[i]);
            b[n-1] = bit'(ones % 2) ^ po;
        end
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < n; i++) m_q.push_back(b[i]);
        m_q.push_back(1'b1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_full = 0; m_busy = 0; m_cur_idle = 0;
            m_idle_pend = 0; m_en_q = 0; m_tick = 0;
        end else begin
            bit old_busy;
            bit go;
            bit discard;
            old_busy = m_busy;
            go = !old_busy && tx_en && m_en_q;
            discard = 0;
            if (old_busy && baud_tick) begin
                m_tick++;
                if (m_tick == 16) begin
                    m_tick = 0;
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_busy = 0;
                    else if (m_q.size() == 1 && !m_cur_idle && !tx_en) discard = 1;
                end
            end
            if (go && m_idle_pend) begin
                m_q.delete();
                for (int i = 0; i < (char9 ? 11 : 10); i++) m_q.push_back(1'b1);
                m_busy = 1; m_cur_idle = 1; m_idle_pend = 0; m_tick = 0;
            end else if (go && m_full) begin
                push_frame(m_data, char9, par_en, par_odd);
                m_busy = 1; m_cur_idle = 0; m_full = 0; m_tick = 0;
            end
            if (discard) m_full = 0;
            if (wr_en) begin
                m_full = 1;
                m_data = int'(wr_data);
            end
            if (tx_en && !m_en_q) m_idle_pend = 1;
            m_en_q = tx_en;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(m_busy ? (m_cur_idle ? "R5" : phase) : "R8", txd, m_busy ? m_q[0] : 1'b1);
            chk("R4", tdr_empty, !m_full);
        end
    end

    // baud tick every other cycle
    initial begin
        forever begin
            @(posedge clk);
            #1 baud_tick = ~baud_tick;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write(int d);
        wr_data = 9'(d);
        wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic wait_quiet();
        cyc(2);
        while (m_busy || (m_full && tx_en) || (m_idle_pend && tx_en)) cyc(1);
        cyc(3);
    endtask

    task automatic wait_data_frame();
        while (!(m_busy && !m_cur_idle)) cyc(1);
    endtask

    task automatic scenario();
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1", txd, 1'b1);
        chk("R1", tdr_empty, 1'b1);

        // R5 preamble, R2 plain 8-bit frame
        phase = "R2";
        tx_en = 1'b1;
        write(9'h0A5);
        chk("R4", tdr_empty, 1'b0);
        cyc(4);
        chk("R5", txd, 1'b1);
        wait_quiet();

        // R2 nine-bit frame
        char9 = 1'b1;
        write(9'h1C3);
        wait_quiet();

        // R3 parity, even in 8-bit, odd in 9-bit
        phase = "R3";
        char9 = 1'b0; par_en = 1'b1; par_odd = 1'b0;
        write(9'h0F1);
        wait_quiet();
        char9 = 1'b1; par_odd = 1'b1;
        write(9'h036);
        wait_quiet();
        par_en = 1'b0; char9 = 1'b0;

        // R6 toggle mid-frame: idle goes ahead of pending data
        phase = "R6";
        write(9'h055);
        wait_data_frame();
        write(9'h0E7);
        cyc(60);
        tx_en = 1'b0;
        cyc(3);
        tx_en = 1'b1;
        wait_quiet();
        chk("R6", tdr_empty, 1'b1);

        // R7 enable still low when the stop bit begins: pending data lost
        phase = "R7";
        write(9'h0C9);
        wait_data_frame();
        write(9'h03C);
        cyc(40);
        tx_en = 1'b0;
        while (m_busy) cyc(1);
        cyc(2);
        chk("R7", tdr_empty, 1'b1);
        tx_en = 1'b1;
        wait_quiet();
        chk("R7", tdr_empty, 1'b1);
        chk("R7", txd, 1'b1);

        // R8 disabled: write is held, nothing starts
        phase = "R8";
        tx_en = 1'b0;
        cyc(2);
        write(9'h09A);
        cyc(200);
        chk("R8", tdr_empty, 1'b0);
        chk("R8", txd, 1'b1);
        phase = "R9";
        char9 = 1'b1;
        tx_en = 1'b1;
        wait_quiet();
        chk("R9", tdr_empty, 1'b1);
    endtask

    initial begin
        fork
            scenario();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                total++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule